// File: doc/BRIEF.md
# DDR Read Latency and Burst Window Timer

This block turns read commands into a latency-aligned data-valid window for a double-data-rate read path. It takes the latency, burst-length and burst-order fields of the first mode register, decodes the 5-bit latency code into a clock count, and tags each accepted read as a full eight-beat burst or a four-beat chop. Each burst is then delayed through a shift pipeline. The latency-decode rule is not monotonic in the code value.

Once the programmed latency has elapsed, the block drives a two-bit valid pair, one bit for each beat of the clock. It also drives the index of the first beat in that pair and the burst-order bit captured with the read. Downstream ordering and data-capture logic use these outputs directly.

Three more duties sit in the same block:
- **Spacing.** A read that arrives too soon after the previous accepted read is refused and flagged.
- **Chop reservation.** A chopped burst still reserves the full four-clock slot.
- **Bad configuration.** An illegal configuration raises an error and stops reads from being accepted.

Top module: `ddr_rd_latency_timer`

## Requirements
- R1: For every defined latency code, the first valid pair appears exactly CL clock edges after the edge that samples the read. The code-to-CL map is:
    - codes 0..7 give 9..16;
    - codes 8, 9, 10, 11 give 18, 20, 22, 24;
    - code 12 gives 23, code 13 gives 17, code 14 gives 19, code 15 gives 21;
    - codes 16, 17 give 25, 26;
    - codes 19..23 give 28..32.
- R2: With burst-length field 2'b00 (fixed eight beats), the valid pair is 2'b11 for four consecutive cycles. The beat index reads 0, 2, 4, 6 across those cycles, and the pair is 2'b00 before and after.
- R3: With burst-length field 2'b10 (fixed chop), the valid pair is 2'b11 for two cycles with index 0 then 2. It is 2'b00 for the remaining two cycles of the reserved slot.
- R4: With burst-length field 2'b01 (chosen per read), the A12 input sampled with the read selects the burst size: A12=1 gives an eight-beat burst and A12=0 gives a four-beat chop.
- R5: The burst-order output equals the burst-type bit sampled with the read whenever the valid pair is nonzero. The burst-order output and the beat index are 0 whenever the valid pair is 2'b00.
- R6: The configuration error output is high, and reads are ignored (no window, no collision), in any of these cases:
    - burst-length field 2'b11;
    - latency code 18;
    - latency codes 24..31.
- R7: A read sampled 1 to 3 edges after an accepted read is dropped. The collision output is high for exactly the one cycle after that edge.
- R8: Reads spaced exactly 4 or more edges apart are all accepted. Their windows follow one another without overlap, so two reads 4 edges apart give eight contiguous valid cycles.
- R9: After reset the valid pair, beat index, burst-order and collision outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cl_code | input | 5 | Latency code from the mode register |
| bl_mode | input | 2 | Burst-length field (00 fixed 8, 01 per read, 10 fixed chop, 11 reserved) |
| burst_type | input | 1 | Burst-order bit (0 sequential, 1 interleaved) |
| rd_strobe | input | 1 | Read command, one cycle per read |
| rd_a12 | input | 1 | A12 sampled with the read (1 = eight beats in per-read mode) |
| beat_valid | output | 2 | Valid pair for the two beats of the current clock |
| beat_idx | output | 3 | Index of the first beat of the current pair |
| burst_order | output | 1 | Burst-order bit of the burst being delivered |
| cfg_err | output | 1 | Illegal latency or burst-length setting |
| collision | output | 1 | A read was dropped for being too close to the previous one |

## Verification
Two functions can fall in the same cycle: refusing a read for spacing, and delivering the window of an earlier read. At a short latency, a refused read can land while an earlier window is running. The bench issues read pairs 1 to 5 edges apart at a 9-clock latency and checks every cycle of the pair. It expects the collision pulse exactly one cycle after a refused read and a single four-cycle window. For accepted pairs it expects two back-to-back windows with no gap or overlap. A full sweep over every latency code, burst-length field, A12 value and burst-order bit also checks the first-beat cycle against a latency rule computed arithmetically in the bench.

// File: rtl/ddr_rlt_pkg.sv
// Package: shared constants, pipeline tag type and latency-code decode
// for the DDR read latency timer.
// Assumes latency codes are 5 bits and CL never exceeds CL_MAX clocks.
package ddr_rlt_pkg;

    localparam int CODE_W     = 5;
    localparam int CL_W       = 6;
    localparam int CL_MAX     = 32;
    localparam int BURST_CLKS = 4;
    localparam int PIPE_DEPTH = CL_MAX + BURST_CLKS;
    localparam int IDX_W      = 3;

    // Burst-length field encodings
    typedef enum logic [1:0] {
        BLM_FIXED8 = 2'b00,
        BLM_PERRD  = 2'b01,
        BLM_FIXED4 = 2'b10,
        BLM_RSVD   = 2'b11
    } blmode_e;

    // One pipeline slot: a live read, its chop flag and its order bit
    typedef struct packed {
        logic live;
        logic chop;
        logic order;
    } rd_tag_t;

    // Latency decode result
    typedef struct packed {
        logic            ok;
        logic [CL_W-1:0] clks;
    } cl_dec_t;

    // Maps a latency code to a clock count; ok=0 for undefined codes
    function automatic cl_dec_t cl_lookup(input logic [CODE_W-1:0] code);
        cl_dec_t r;
        r.ok   = 1'b1;
        r.clks = 6'd9;
        case (code)
            5'd0:  r.clks = 6'd9;
            5'd1:  r.clks = 6'd10;
            5'd2:  r.clks = 6'd11;
            5'd3:  r.clks = 6'd12;
            5'd4:  r.clks = 6'd13;
            5'd5:  r.clks = 6'd14;
            5'd6:  r.clks = 6'd15;
            5'd7:  r.clks = 6'd16;
            5'd8:  r.clks = 6'd18;
            5'd9:  r.clks = 6'd20;
            5'd10: r.clks = 6'd22;
            5'd11: r.clks = 6'd24;
            5'd12: r.clks = 6'd23;
            5'd13: r.clks = 6'd17;
            5'd14: r.clks = 6'd19;
            5'd15: r.clks = 6'd21;
            5'd16: r.clks = 6'd25;
            5'd17: r.clks = 6'd26;
            5'd19: r.clks = 6'd28;
            5'd20: r.clks = 6'd29;
            5'd21: r.clks = 6'd30;
            5'd22: r.clks = 6'd31;
            5'd23: r.clks = 6'd32;
            default: r.ok = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rlt_cfg_decode.sv
// Module: configuration decode. Turns the latency code and burst-length
// field into a clock count, a chop request for the current read and an
// error flag.
// Assumes the configuration is held stable while reads are in flight.
module rlt_cfg_decode
    import ddr_rlt_pkg::*;
(
    input  logic [CODE_W-1:0] cl_code,
    input  logic [1:0]        bl_mode,
    input  logic              rd_a12,
    output logic [CL_W-1:0]   cl_clks,
    output logic              chop_req,
    output logic              cfg_err
);

    cl_dec_t dec;
    blmode_e mode;

    // Latency lookup and burst-length field typing
    always_comb begin
        dec  = cl_lookup(cl_code);
        mode = blmode_e'(bl_mode);
    end

    // Chop selection per mode and the combined error flag
    always_comb begin
        chop_req = 1'b0;
        cfg_err  = !dec.ok;
        case (mode)
            BLM_FIXED8: chop_req = 1'b0;
            BLM_PERRD:  chop_req = !rd_a12;
            BLM_FIXED4: chop_req = 1'b1;
            default:    cfg_err  = 1'b1;
        endcase
        cl_clks = dec.clks;
    end

endmodule

// File: rtl/rlt_issue_gate.sv
// Module: read admission. Accepts a read only when the configuration is
// legal and at least MIN_GAP edges have passed since the last accepted
// read. A refused read pulses the collision output for one cycle.
// Assumes MIN_GAP >= 4 so that a burst slot never overlaps the next one.
module rlt_issue_gate
    import ddr_rlt_pkg::*;
#(
    parameter int MIN_GAP = BURST_CLKS
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rd_strobe,
    input  logic    cfg_err,
    input  logic    chop_req,
    input  logic    order_in,
    output rd_tag_t new_tag,
    output logic    collision
);

    localparam int GW = $clog2(MIN_GAP + 1);

    logic [GW-1:0] gap_q;
    logic          too_close;
    logic          accept;
    logic          refuse;

    // Spacing test and the accept or refuse decision
    always_comb begin
        too_close = gap_q < GW'(MIN_GAP);
        accept    = rst_n & rd_strobe & ~cfg_err & ~too_close;
        refuse    = rst_n & rd_strobe & ~cfg_err &  too_close;
    end

    // Tag handed to the delay line; cleared when nothing is accepted
    always_comb begin
        new_tag.live  = accept;
        new_tag.chop  = accept & chop_req;
        new_tag.order = accept & order_in;
    end

    // Edge counter since the last accept and the registered collision pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q     <= GW'(MIN_GAP);
            collision <= 1'b0;
        end else begin
            collision <= refuse;
            if (accept)
                gap_q <= GW'(1);
            else if (too_close)
                gap_q <= gap_q + GW'(1);
        end
    end

    // Accepted reads are never closer than four edges apart
    assert_accept_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (!$past(accept) && !$past(accept, 2) && !$past(accept, 3)));

    // A collision pulse follows only a refused read
    assert_collision_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> ($past(rd_strobe) && !$past(accept)));

endmodule

// File: rtl/rlt_delay_line.sv
// Module: latency delay line. A plain shift register of read tags; the
// tag accepted at edge k sits in stage j after edge k+j.
// Assumes DEPTH covers the largest latency plus the burst slot.
module rlt_delay_line
    import ddr_rlt_pkg::*;
#(
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  rd_tag_t               in_tag,
    output rd_tag_t [DEPTH-1:0]   stages
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        rd_tag_t src;

        // Select the feed of this stage
        if (s == 0) begin : g_head
            assign src = in_tag;
        end else begin : g_body
            assign src = stages[s-1];
        end

        // Advance one tag per clock
        always_ff @(posedge clk) begin
            if (!rst_n)
                stages[s] <= '0;
            else
                stages[s] <= src;
        end
    end

endmodule

// File: rtl/rlt_window_sel.sv
// Module: window selection. Looks at the four stages that follow the
// programmed latency and drives the valid pair, beat index and order bit.
// Assumes reads are spaced so at most one of the four stages is live.
module rlt_window_sel
    import ddr_rlt_pkg::*;
#(
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rd_tag_t [DEPTH-1:0] stages,
    input  logic [CL_W-1:0]     cl_clks,
    output logic [1:0]          beat_valid,
    output logic [IDX_W-1:0]    beat_idx,
    output logic                burst_order
);

    rd_tag_t                win [BURST_CLKS];
    logic [BURST_CLKS-1:0]  hit;

    for (genvar o = 0; o < BURST_CLKS; o++) begin : g_off
        logic [CL_W-1:0] sel;

        // Tap the stage that is o clocks past the latency point
        always_comb begin
            sel    = cl_clks + CL_W'(o);
            win[o] = stages[sel];
            hit[o] = win[o].live;
        end
    end

    // Drive the outputs from whichever tap holds a live burst
    always_comb begin
        beat_valid  = 2'b00;
        beat_idx    = '0;
        burst_order = 1'b0;
        for (int o = 0; o < BURST_CLKS; o++) begin
            if (hit[o] && (o < BURST_CLKS / 2 || !win[o].chop)) begin
                beat_valid  = 2'b11;
                beat_idx    = IDX_W'(2 * o);
                burst_order = win[o].order;
            end
        end
    end

    // Spacing keeps the window taps free of overlap
    assert_single_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/ddr_rd_latency_timer.sv
// Module: top of the DDR read latency and burst window timer. Wires the
// configuration decode, read admission, delay line and window selection.
// Assumes the configuration inputs change only while no read is in flight.
module ddr_rd_latency_timer
    import ddr_rlt_pkg::*;
#(
    parameter int MIN_GAP = BURST_CLKS,
    parameter int DEPTH   = PIPE_DEPTH
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] cl_code,
    input  logic [1:0] bl_mode,
    input  logic       burst_type,
    input  logic       rd_strobe,
    input  logic       rd_a12,
    output logic [1:0] beat_valid,
    output logic [2:0] beat_idx,
    output logic       burst_order,
    output logic       cfg_err,
    output logic       collision
);

    logic [CL_W-1:0]     cl_clks;
    logic                chop_req;
    rd_tag_t             new_tag;
    rd_tag_t [DEPTH-1:0] stages;

    rlt_cfg_decode i_cfg (
        .cl_code  (cl_code),
        .bl_mode  (bl_mode),
        .rd_a12   (rd_a12),
        .cl_clks  (cl_clks),
        .chop_req (chop_req),
        .cfg_err  (cfg_err)
    );

    rlt_issue_gate #(.MIN_GAP(MIN_GAP)) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .cfg_err   (cfg_err),
        .chop_req  (chop_req),
        .order_in  (burst_type),
        .new_tag   (new_tag),
        .collision (collision)
    );

    rlt_delay_line #(.DEPTH(DEPTH)) i_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_tag (new_tag),
        .stages (stages)
    );

    rlt_window_sel #(.DEPTH(DEPTH)) i_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .stages      (stages),
        .cl_clks     (cl_clks),
        .beat_valid  (beat_valid),
        .beat_idx    (beat_idx),
        .burst_order (burst_order)
    );

    // A tag enters the delay line only for a read seen under legal settings
    assert_err_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stages[0].live |-> $past(rd_strobe && !cfg_err));

    // Every window opens with beat index 0
    assert_window_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid[0]) |-> (beat_idx == 3'd0));

    // Within a window the index advances by two beats per clock
    assert_idx_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid[0] && beat_idx != 3'd0) |->
            ($past(beat_valid[0]) && beat_idx == 3'($past(beat_idx) + 3'd2)));

    // Idle outputs carry no stale order bit or index
    assert_idle_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid == 2'b00) |-> (burst_order == 1'b0 && beat_idx == 3'd0));

endmodule

// File: tb/test_ddr_rd_latency_timer.sv
`timescale 1ns/1ps
module test_ddr_rd_latency_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cl_code = '0;
    logic [1:0] bl_mode = '0;
    logic       burst_type = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       rd_a12 = 1'b0;
    logic [1:0] beat_valid;
    logic [2:0] beat_idx;
    logic       burst_order;
    logic       cfg_err;
    logic       collision;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ddr_rd_latency_timer i_ddr_rd_latency_timer (
        .clk(clk), .rst_n(rst_n), .cl_code(cl_code), .bl_mode(bl_mode),
        .burst_type(burst_type), .rd_strobe(rd_strobe), .rd_a12(rd_a12),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .burst_order(burst_order),
        .cfg_err(cfg_err), .collision(collision)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Latency rule written arithmetically; -1 marks an undefined code
    function automatic int exp_cl(input int c);
        if (c < 8)  return 9 + c;
        if (c < 12) return 18 + 2 * (c - 8);
        if (c == 12) return 23;
        if (c < 16) return 17 + 2 * (c - 13);
        if (c == 18) return -1;
        if (c < 24) return 9 + c;
        return -1;
    endfunction

    // One read under one configuration, every output cycle compared
    task automatic run_one(input int c, input int bl, input int bt, input int a);
        int  cl;
        bit  bad;
        bit  chop;
        string rq;
        @(negedge clk);
        cl_code = 5'(c); bl_mode = 2'(bl); burst_type = bt[0]; rd_a12 = a[0];
        cl   = exp_cl(c);
        bad  = (cl < 0) || (bl == 3);
        chop = (bl == 2) || (bl == 1 && a == 0);
        rq   = bad ? "R6" : (bl == 1 ? "R4" : (bl == 2 ? "R3" : "R2"));
        #0.1;
        check(cfg_err == bad, "R6", "cfg_err", cfg_err, bad);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        for (int m = 0; m <= 40; m++) begin
            int  o = m - cl;
            bit  v = !bad && o >= 0 && o < 4 && (o < 2 || !chop);
            check(beat_valid == (v ? 2'b11 : 2'b00), (o == 0 && !bad) ? "R1" : rq,
                  "beat_valid", beat_valid, v ? 3 : 0);
            check(beat_idx == (v ? 3'(2 * o) : 3'd0), rq, "beat_idx",
                  beat_idx, v ? 2 * o : 0);
            check(burst_order == (v ? bt[0] : 1'b0), "R5", "burst_order",
                  burst_order, v ? bt : 0);
            if (m == 0)
                check(collision == 1'b0, bad ? "R6" : "R7", "collision", collision, 0);
            @(negedge clk);
        end
    endtask

    // Two reads gap edges apart at a 9-clock latency, fixed eight beats
    task automatic run_pair(input int gap);
        @(negedge clk);
        cl_code = 5'd0; bl_mode = 2'b00; burst_type = 1'b1; rd_a12 = 1'b0;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        for (int m = 0; m <= 30; m++) begin
            bit w1 = (m >= 9 && m <= 12);
            bit w2 = (gap >= 4) && (m >= gap + 9 && m <= gap + 12);
            bit cx = (gap < 4) && (m == gap);
            check(beat_valid == ((w1 || w2) ? 2'b11 : 2'b00), gap < 4 ? "R7" : "R8",
                  "pair valid", beat_valid, (w1 || w2) ? 3 : 0);
            check(collision == cx, "R7", "collision", collision, cx);
            rd_strobe = (m == gap - 1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(beat_valid == 2'b00, "R9", "reset valid", beat_valid, 0);
        check(beat_idx == 3'd0, "R9", "reset idx", beat_idx, 0);
        check(burst_order == 1'b0, "R9", "reset order", burst_order, 0);
        check(collision == 1'b0, "R9", "reset collision", collision, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(beat_valid == 2'b00, "R9", "post-reset valid", beat_valid, 0);
        for (int g = 1; g <= 5; g++) run_pair(g);
        for (int c = 0; c < 32; c++)
            for (int bl = 0; bl < 4; bl++)
                for (int bt = 0; bt < 2; bt++)
                    for (int a = 0; a < 2; a++)
                        run_one(c, bl, bt, a);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule